// File: doc/BRIEF.md
# Operand Addressing Mode Unit

This unit resolves the operand of an 8-bit accumulator machine instruction. The decoder presents a mode code, the instruction's 16-bit operand field, the program counter of the instruction, its length in bytes, and the values of the general register R, the index register X, the base register and the implied register selected by the opcode. It then pulses `start`.

The unit latches everything at the accepting edge. It then forms an effective address, issues zero, one or two reads on a byte-wide memory port, and returns the 8-bit operand together with a one-cycle `done` pulse.

The memory port is a request/response pair. `mem_req` is high for one cycle with `mem_addr`. The memory answers with `mem_rvalid` and `mem_rdata`, at the earliest one cycle later. With one-cycle memory the latency from the accepting edge to `done` is 1 cycle with no read, 3 cycles with one read and 5 cycles with two reads.

Top module: `opf_unit`

## Requirements
- R1: After reset `busy`, `done` and `mem_req` are all low.
- R2: Mode code 0 (direct) reads address `field`. The byte returned is the operand, with one read and `done` 3 cycles after the accepting edge.
- R3: Mode code 1 (indirect) first reads address `field` to obtain a byte P. It then reads address {8'h00, P}, and that second byte is the operand. This takes two reads, with `done` 5 cycles after the accepting edge.
- R4: Mode code 2 (register direct) returns `reg_r` as the operand. It makes no memory read, and `done` follows 1 cycle after the accepting edge.
- R5: Mode code 3 (register indirect) reads address {8'h00, `reg_r`}, with one read.
- R6: Mode code 4 (immediate) returns `field[7:0]`. It makes no read and has 1-cycle latency.
- R7: Mode code 5 (implicit) returns `implied_reg`. It makes no read and has 1-cycle latency.
- R8: Mode code 6 (relative) reads address `pc + ilen + field`, modulo 2^16, with one read.
- R9: Mode code 7 (indexed) reads `field + reg_x`, and mode code 8 (base) reads `field + reg_base`. Both sums wrap modulo 2^16, and each takes one read.
- R10: A `start` seen while `busy` is high is ignored. `busy` covers the cycles from the accepting edge through the `done` cycle. Inputs changed after acceptance do not affect the result.
- R11: `done` is high for exactly one cycle per accepted request, and `operand` is valid in that cycle.
- R12: Mode codes 9 to 15 return operand 0 with no read and 1-cycle latency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request strobe, taken only while idle |
| mode | input | 4 | Addressing mode code |
| field | input | 16 | Operand field of the instruction |
| pc | input | 16 | Address of the current instruction |
| ilen | input | 2 | Instruction length in bytes |
| reg_r | input | 8 | General register R |
| reg_x | input | 16 | Index register |
| reg_base | input | 16 | Base register |
| implied_reg | input | 8 | Register implied by the opcode |
| mem_req | output | 1 | Read request strobe |
| mem_addr | output | 16 | Read address |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 8 | Read data |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle result strobe |
| operand | output | 8 | Resolved operand |

## Verification
Faults in the sequencer or the latched request show up at the ports within a single request. A wrong effective-address term appears on `mem_addr` in the first read cycle. A lost or extra pointer hop changes both the read count and the `done` latency by two cycles. A stray acceptance while busy produces an extra `done` a few cycles later, with nothing queued to match it. Each request is therefore scored on its operand, its final read address, its read count and its latency, and a `done` with nothing expected is itself an error.

// File: rtl/opf_pkg.sv
package opf_pkg;

  typedef enum logic [3:0] {
    M_DIRECT = 4'd0,
    M_INDIR  = 4'd1,
    M_REGDIR = 4'd2,
    M_REGIND = 4'd3,
    M_IMM    = 4'd4,
    M_IMPL   = 4'd5,
    M_REL    = 4'd6,
    M_INDEX  = 4'd7,
    M_BASE   = 4'd8
  } amode_e;

  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_ISSUE = 2'd1,
    S_WAIT  = 2'd2,
    S_FIN   = 2'd3
  } fsm_e;

  // true for modes whose operand lives in memory
  function automatic logic needs_mem(input logic [3:0] m);
    case (m)
      M_DIRECT, M_INDIR, M_REGIND, M_REL, M_INDEX, M_BASE: needs_mem = 1'b1;
      default:                                              needs_mem = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/opf_ea_calc.sv
module opf_ea_calc import opf_pkg::*; #(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter int LW = 2
) (
  input  logic [3:0]    mode_q,
  input  logic [AW-1:0] field_q,
  input  logic [AW-1:0] pc_q,
  input  logic [LW-1:0] len_q,
  input  logic [DW-1:0] r_q,
  input  logic [AW-1:0] x_q,
  input  logic [AW-1:0] base_q,
  input  logic          hop2,
  input  logic [DW-1:0] ptr_q,
  output logic [AW-1:0] ea
);
  localparam int PAD_D = AW - DW;
  localparam int PAD_L = AW - LW;

  function automatic logic [AW-1:0] wrap_sum(input logic [AW-1:0] a,
                                             input logic [AW-1:0] b);
    wrap_sum = a + b;
  endfunction

  function automatic logic [AW-1:0] zext_byte(input logic [DW-1:0] v);
    zext_byte = {{PAD_D{1'b0}}, v};
  endfunction

  logic [AW-1:0] next_insn;
  assign next_insn = wrap_sum(pc_q, {{PAD_L{1'b0}}, len_q});

  always_comb begin
    if (hop2) begin
      ea = zext_byte(ptr_q);
    end else begin
      case (mode_q)
        M_REGIND: ea = zext_byte(r_q);
        M_REL:    ea = wrap_sum(next_insn, field_q);
        M_INDEX:  ea = wrap_sum(field_q, x_q);
        M_BASE:   ea = wrap_sum(field_q, base_q);
        default:  ea = field_q;
      endcase
    end
  end

endmodule

// File: rtl/opf_ctrl.sv
module opf_ctrl import opf_pkg::*; #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic [3:0]    mode_in,
  input  logic [DW-1:0] field_lo,
  input  logic [DW-1:0] r_in,
  input  logic [DW-1:0] imp_in,
  input  logic [3:0]    mode_q,
  input  logic          mem_rvalid,
  input  logic [DW-1:0] mem_rdata,
  output logic          mem_req,
  output logic          hop2,
  output logic [DW-1:0] ptr_q,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] operand
);
  fsm_e st;

  // named internal events
  logic rd_back, take_ptr, take_data;
  assign rd_back   = (st == S_WAIT) && mem_rvalid;
  assign take_ptr  = rd_back && (mode_q == M_INDIR) && !hop2;
  assign take_data = rd_back && !take_ptr;

  function automatic logic [DW-1:0] reg_value(input logic [3:0] m,
                                              input logic [DW-1:0] f,
                                              input logic [DW-1:0] r,
                                              input logic [DW-1:0] imp);
    case (m)
      M_REGDIR: reg_value = r;
      M_IMM:    reg_value = f;
      M_IMPL:   reg_value = imp;
      default:  reg_value = '0;
    endcase
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      hop2    <= 1'b0;
      ptr_q   <= '0;
      operand <= '0;
    end else begin
      case (st)
        S_IDLE: if (accept) begin
          hop2 <= 1'b0;
          if (needs_mem(mode_in)) begin
            st <= S_ISSUE;
          end else begin
            operand <= reg_value(mode_in, field_lo, r_in, imp_in);
            st      <= S_FIN;
          end
        end
        S_ISSUE: st <= S_WAIT;
        S_WAIT: begin
          if (take_ptr) begin
            ptr_q <= mem_rdata;
            hop2  <= 1'b1;
            st    <= S_ISSUE;
          end else if (take_data) begin
            operand <= mem_rdata;
            st      <= S_FIN;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign mem_req = (st == S_ISSUE);
  assign busy    = (st != S_IDLE);
  assign done    = (st == S_FIN);

  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_regdir_no_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && mode_q == M_REGDIR) |-> !mem_req);

  assert_reserved_no_read_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && mode_q > M_BASE) |-> !mem_req);

  assert_mem_done_after_data_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (done && needs_mem(mode_q)) |-> $past(mem_rvalid));

endmodule

// File: rtl/opf_unit.sv
module opf_unit import opf_pkg::*; #(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter int LW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [3:0]    mode,
  input  logic [AW-1:0] field,
  input  logic [AW-1:0] pc,
  input  logic [LW-1:0] ilen,
  input  logic [DW-1:0] reg_r,
  input  logic [AW-1:0] reg_x,
  input  logic [AW-1:0] reg_base,
  input  logic [DW-1:0] implied_reg,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_rvalid,
  input  logic [DW-1:0] mem_rdata,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] operand
);
  logic          accept;
  logic          hop2;
  logic [DW-1:0] ptr_q;
  logic [3:0]    mode_q;
  logic [AW-1:0] field_q, pc_q, x_q, base_q;
  logic [LW-1:0] len_q;
  logic [DW-1:0] r_q;

  assign accept = start && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= '0;
      field_q <= '0;
      pc_q    <= '0;
      len_q   <= '0;
      r_q     <= '0;
      x_q     <= '0;
      base_q  <= '0;
    end else if (accept) begin
      mode_q  <= mode;
      field_q <= field;
      pc_q    <= pc;
      len_q   <= ilen;
      r_q     <= reg_r;
      x_q     <= reg_x;
      base_q  <= reg_base;
    end
  end

  opf_ea_calc #(.AW(AW), .DW(DW), .LW(LW)) u_ea (
    .mode_q (mode_q),
    .field_q(field_q),
    .pc_q   (pc_q),
    .len_q  (len_q),
    .r_q    (r_q),
    .x_q    (x_q),
    .base_q (base_q),
    .hop2   (hop2),
    .ptr_q  (ptr_q),
    .ea     (mem_addr)
  );

  opf_ctrl #(.DW(DW)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .mode_in   (mode),
    .field_lo  (field[DW-1:0]),
    .r_in      (reg_r),
    .imp_in    (implied_reg),
    .mode_q    (mode_q),
    .mem_rvalid(mem_rvalid),
    .mem_rdata (mem_rdata),
    .mem_req   (mem_req),
    .hop2      (hop2),
    .ptr_q     (ptr_q),
    .busy      (busy),
    .done      (done),
    .operand   (operand)
  );

  assert_start_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> ($stable(mode_q) && $stable(field_q)));

  assert_ptr_hop_page0_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && hop2) |-> (mem_addr[AW-1:DW] == '0));

  assert_req_while_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> busy);

endmodule

// File: tb/opf_unit_bench.sv
module opf_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [3:0]  mode = '0;
  logic [15:0] field = '0, pc = '0, reg_x = '0, reg_base = '0;
  logic [1:0]  ilen = '0;
  logic [7:0]  reg_r = '0, implied_reg = '0;
  logic        mem_req, busy, done;
  logic [15:0] mem_addr;
  logic        mem_rvalid = 1'b0;
  logic [7:0]  mem_rdata = '0;
  logic [7:0]  operand;

  always #2 clk = ~clk;  // 250 MHz

  opf_unit u_opf_unit (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .field(field),
    .pc(pc), .ilen(ilen), .reg_r(reg_r), .reg_x(reg_x), .reg_base(reg_base),
    .implied_reg(implied_reg), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .busy(busy),
    .done(done), .operand(operand)
  );

  // memory image computed from the address
  function automatic logic [7:0] memf(input logic [15:0] a);
    memf = a[7:0] ^ {a[14:8], a[15]} ^ 8'hA5;
  endfunction

  always @(posedge clk) begin
    mem_rvalid <= mem_req;
    mem_rdata  <= memf(mem_addr);
  end

  typedef struct {
    logic [7:0]  opnd;
    logic [15:0] addr;
    int          reads;
    string       tag;
  } exp_t;

  exp_t q[$];
  int checks = 0, fails = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
    end
  endtask

  // monitor
  int  cyc = 0, reads = 0;
  logic [15:0] last_addr = '0;
  initial begin
    forever begin
      @(negedge clk);
      if (start && !busy) begin
        cyc = 0; reads = 0;
      end else begin
        cyc++;
        if (mem_req) begin
          reads++;
          last_addr = mem_addr;
        end
        if (done) begin
          if (q.size() == 0) begin
            chk(1'b0, "R11", "unexpected done", 1, 0);
          end else begin
            exp_t e;
            int lat;
            e = q.pop_front();
            lat = (e.reads == 0) ? 1 : 1 + 2 * e.reads;
            chk(operand == e.opnd, e.tag, "operand", operand, e.opnd);
            chk(reads == e.reads, e.tag, "read count", reads, e.reads);
            chk(cyc == lat, e.tag, "latency", cyc, lat);
            if (e.reads > 0)
              chk(last_addr == e.addr, e.tag, "final address", last_addr, e.addr);
          end
        end
      end
    end
  end

  task automatic issue(input logic [3:0] m, input logic [15:0] f,
                       input logic [15:0] p, input logic [1:0] l,
                       input logic [7:0] r, input logic [15:0] x,
                       input logic [15:0] b, input logic [7:0] imp,
                       input logic [7:0] eop, input logic [15:0] eaddr,
                       input int erd, input string tag, input bit glitch);
    exp_t e;
    e.opnd = eop; e.addr = eaddr; e.reads = erd; e.tag = tag;
    q.push_back(e);
    @(posedge clk); #1;
    mode = m; field = f; pc = p; ilen = l; reg_r = r; reg_x = x;
    reg_base = b; implied_reg = imp; start = 1'b1;
    @(posedge clk); #1;
    // disturb the inputs after acceptance
    mode = 4'd4; field = 16'hDEFF; reg_r = 8'h11; reg_x = 16'h7777;
    reg_base = 16'h5555; implied_reg = 8'h99; pc = 16'h3333;
    start = glitch;
    @(posedge clk); #1;
    start = 1'b0;
    while (q.size() != 0) @(posedge clk);
    repeat (6) @(posedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(busy == 1'b0, "R1", "busy in reset", busy, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0, "R1", "busy after reset", busy, 0);
    chk(done == 1'b0, "R1", "done after reset", done, 0);
    chk(mem_req == 1'b0, "R1", "mem_req after reset", mem_req, 0);

    // R2 direct
    issue(4'd0, 16'h1234, 0, 0, 0, 0, 0, 0, memf(16'h1234), 16'h1234, 1, "R2", 0);
    issue(4'd0, 16'hFFFF, 0, 0, 0, 0, 0, 0, memf(16'hFFFF), 16'hFFFF, 1, "R2", 0);
    // R3 indirect: pointer byte then page-0 read
    begin
      logic [7:0] p1;
      p1 = memf(16'h0340);
      issue(4'd1, 16'h0340, 0, 0, 0, 0, 0, 0, memf({8'h00, p1}), {8'h00, p1}, 2, "R3", 0);
    end
    // R4 register direct, with a start held into the busy cycle
    issue(4'd2, 16'h0000, 0, 0, 8'h9C, 0, 0, 0, 8'h9C, 0, 0, "R4", 1);
    // R5 register indirect
    issue(4'd3, 16'h4444, 0, 0, 8'h33, 0, 0, 0, memf(16'h0033), 16'h0033, 1, "R5", 0);
    // R6 immediate
    issue(4'd4, 16'hAB7E, 0, 0, 0, 0, 0, 0, 8'h7E, 0, 0, "R6", 0);
    // R7 implicit
    issue(4'd5, 16'h1111, 0, 0, 8'h01, 0, 0, 8'h42, 8'h42, 0, 0, "R7", 0);
    // R8 relative: pc 10, length 2, offset 5 -> 17; and wrap
    issue(4'd6, 16'h0005, 16'd10, 2'd2, 0, 0, 0, 0, memf(16'd17), 16'd17, 1, "R8", 0);
    issue(4'd6, 16'h0005, 16'hFFFE, 2'd2, 0, 0, 0, 0, memf(16'h0005), 16'h0005, 1, "R8", 0);
    // R9 indexed and base
    issue(4'd7, 16'h0005, 0, 0, 0, 16'd10, 16'h2000, 0, memf(16'd15), 16'd15, 1, "R9", 0);
    issue(4'd7, 16'h0020, 0, 0, 0, 16'hFFF0, 0, 0, memf(16'h0010), 16'h0010, 1, "R9", 0);
    issue(4'd8, 16'h0100, 0, 0, 0, 16'h0040, 16'h2000, 0, memf(16'h2100), 16'h2100, 1, "R9", 0);
    // R12 reserved code
    issue(4'd9, 16'h00FF, 0, 0, 8'h77, 0, 0, 8'h66, 8'h00, 0, 0, "R12", 0);
    // R10 start held high while busy on a memory mode
    issue(4'd0, 16'h0ACE, 0, 0, 0, 0, 0, 0, memf(16'h0ACE), 16'h0ACE, 1, "R10", 1);
    @(negedge clk);
    chk(busy == 1'b0, "R10", "idle after ignored start", busy, 0);

    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule